// File: doc/BRIEF.md
# Configurable Alternate-Function Port Pin Controller

This block is the controller for a port of configurable pins. Each pin can be a plain input, an output driven from a software data register, a bidirectional pin with a weak pull-up, or an output driven by on-chip peripherals. A pin can also be handed to an analog function. A three-bit code per pin selects the mode. The bits of that code are held in three configuration registers, and each register holds one code bit for every pin. The block turns the code, the data register and the peripheral outputs into three per-pin pad controls: an output value, a drive enable and a weak pull-up enable.

Two return paths carry the pin level back. The data-register read path goes through a two-flop synchronizer. The peripheral input path is not synchronized. The peripheral inputs see the pad as it is, so a level the port drives itself is visible to them. More than one peripheral can drive the same pin, and their outputs are combined by an AND. Any peripheral that is idle must therefore hold its output at 1. Pins that are fixed for analog use (set by a parameter) are released when they carry code 111: their digital level is no longer reported. A low-power input freezes the pad controls while the core sleeps.

Top module: `afio_port`

## Requirements
- R1: Registers are written on a clock edge when `bus_we` is high. Address 0 is the data register, and addresses 1, 2 and 3 hold mode bits C0, C1 and C2. A pin's mode code is {C2,C1,C0}. `bus_rdata` returns the selected configuration register for addresses 1–3 and the synchronized pin level for address 0.
- R2: Reset loads the data register with all ones and every pin with code 100. The pads come out of reset with drive enable 0, output value 1, and pull-up equal to the `PULLUP_EN` option. That option set to 0 leaves the pins high impedance.
- R3: Code 000 is an input with pull-up and code 001 is a high-impedance input. In both, the drive enable is 0 and the output value follows the data bit.
- R4: Code 010 is a push-pull output: the output value is the data bit, the drive enable is 1 and the pull-up is 0.
- R5: Code 011 is an open-drain output: the output value is the data bit, the drive is enabled only while that bit is 0, and the pull-up is 0.
- R6: Code 100 is bidirectional: the output value is the data bit, the drive is enabled only while that bit is 0, and the pull-up equals `PULLUP_EN`.
- R7: Codes 101 (push-pull) and 110 (open-drain) take the output value from the AND of all `NUM_AF` peripheral outputs of that pin. Code 101 always drives. Code 110 drives only a 0. A pin outside `ANALOG_MASK` treats code 111 like 110.
- R8: A pin inside `ANALOG_MASK` with code 111 outputs 1 with drive enable 0 and pull-up 0. Its bit reads 0 on both `bus_rdata` (address 0) and `af_in`.
- R9: `af_in` is unsynchronized. It shows `pin_in` while the pin is not driven and the driven `pin_out` value while `pin_oe` is 1.
- R10: A change on `pin_in` reaches `bus_rdata` at address 0 after exactly two clock edges. It does so in every mode except the R8 analog case, including the peripheral modes.
- R11: Pad controls are registered. They reflect register writes and peripheral output changes one edge later. While `sleep` is high they hold their values, although register writes are still accepted. The accepted writes take effect on the first edge after `sleep` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Low-power request; freezes pad controls |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data (combinational on address) |
| pin_in | input | WIDTH | Pad input level |
| pin_out | output | WIDTH | Pad output value |
| pin_oe | output | WIDTH | Pad drive enable |
| pin_pu | output | WIDTH | Pad weak pull-up enable |
| af_out | input | NUM_AF*WIDTH | Peripheral outputs; source k for pin i is bit k*WIDTH+i |
| af_in | output | WIDTH | Pin level to peripheral inputs |

## Verification
A register write is captured on one edge, and the pad controls follow on the next edge. A peripheral output change needs only one edge. The bench therefore drives stimulus at a falling edge and samples pad controls at the falling edge after the second rising edge for writes, and after the first rising edge for peripheral changes. For the synchronizer, the bench samples `bus_rdata` after one edge, when the old value is still expected, and again after two edges. `af_in` is combinational from the pad registers and `pin_in`, so it is checked shortly after its input changes. During `sleep` the bench samples over several edges to confirm that the controls stay frozen, and again one edge after wake-up.

// File: rtl/afio_pkg.sv
// Package: shared encodings for the alternate-function port controller.
// Assumes a 3-bit per-pin mode code assembled as {C2,C1,C0}.
package afio_pkg;

    typedef enum logic [2:0] {
        MODE_IN_PU  = 3'b000,
        MODE_IN_HZ  = 3'b001,
        MODE_PP     = 3'b010,
        MODE_OD     = 3'b011,
        MODE_BIDIR  = 3'b100,
        MODE_AF_PP  = 3'b101,
        MODE_AF_OD  = 3'b110,
        MODE_AF_ANA = 3'b111
    } pin_mode_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CFG0 = 2'd1;
    localparam logic [1:0] ADDR_CFG1 = 2'd2;
    localparam logic [1:0] ADDR_CFG2 = 2'd3;

    // Per-pin pad control bundle
    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
        logic ana;
    } pin_stat_t;

endpackage

// File: rtl/afio_regs.sv
// Module: register file holding the data register and three mode-bit registers.
// Assumes a single-cycle write strobe; reset state puts every pin in code 100.
module afio_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] cfg0_q,
    output logic [WIDTH-1:0] cfg1_q,
    output logic [WIDTH-1:0] cfg2_q
);
    import afio_pkg::*;

    // Capture writes into the addressed register; reset to bidirectional pull-up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
            cfg0_q <= '0;
            cfg1_q <= '0;
            cfg2_q <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_DATA: data_q <= wr_data;
                ADDR_CFG0: cfg0_q <= wr_data;
                ADDR_CFG1: cfg1_q <= wr_data;
                ADDR_CFG2: cfg2_q <= wr_data;
                default:   data_q <= data_q;
            endcase
        end
    end

endmodule

// File: rtl/afio_in_sync.sv
// Module: multi-stage synchronizer for the pin input read path.
// Assumes STAGES >= 2; each bit is synchronized independently.
module afio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/afio_pin_decode.sv
// Module: combinational mode decode for one pin.
// Produces output value, drive enable, pull-up and analog flag from the mode
// code, the data bit and the AND of the peripheral outputs sharing the pin.
// Assumes idle peripherals hold their output at 1.
module afio_pin_decode #(
    parameter int NUM_AF    = 2,
    parameter bit ANALOG    = 1'b0,
    parameter bit PULLUP_EN = 1'b1
) (
    input  afio_pkg::pin_mode_e mode,
    input  logic                data_bit,
    input  logic [NUM_AF-1:0]   af_bits,
    output afio_pkg::pin_stat_t stat
);
    import afio_pkg::*;

    logic af_and;

    // Combine shared peripheral outputs by AND
    assign af_and = &af_bits;

    // Translate the mode code into pad controls
    always_comb begin
        stat.out = data_bit;
        stat.oe  = 1'b0;
        stat.pu  = 1'b0;
        stat.ana = 1'b0;
        unique case (mode)
            MODE_IN_PU: stat.pu = PULLUP_EN;
            MODE_IN_HZ: stat.pu = 1'b0;
            MODE_PP:    stat.oe = 1'b1;
            MODE_OD:    stat.oe = ~data_bit;
            MODE_BIDIR: begin
                stat.oe = ~data_bit;
                stat.pu = PULLUP_EN;
            end
            MODE_AF_PP: begin
                stat.out = af_and;
                stat.oe  = 1'b1;
            end
            MODE_AF_OD: begin
                stat.out = af_and;
                stat.oe  = ~af_and;
            end
            MODE_AF_ANA: begin
                if (ANALOG) begin
                    stat.out = 1'b1;
                    stat.oe  = 1'b0;
                    stat.ana = 1'b1;
                end else begin
                    stat.out = af_and;
                    stat.oe  = ~af_and;
                end
            end
            default: stat.oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/afio_port.sv
// Module: top of the alternate-function port controller.
// Holds registers, decodes each pin's mode, registers the pad controls
// (frozen while sleep is high), returns the synchronized pin level on the
// read bus and the raw or looped-back level to peripheral inputs.
// Assumes af_out source k for pin i sits at bit k*WIDTH+i.
module afio_port #(
    parameter int               WIDTH       = 8,
    parameter int               NUM_AF      = 2,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] ANALOG_MASK = '0,
    parameter bit               PULLUP_EN   = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    bus_we,
    input  logic [1:0]              bus_addr,
    input  logic [WIDTH-1:0]        bus_wdata,
    output logic [WIDTH-1:0]        bus_rdata,
    input  logic [WIDTH-1:0]        pin_in,
    output logic [WIDTH-1:0]        pin_out,
    output logic [WIDTH-1:0]        pin_oe,
    output logic [WIDTH-1:0]        pin_pu,
    input  logic [NUM_AF*WIDTH-1:0] af_out,
    output logic [WIDTH-1:0]        af_in
);
    import afio_pkg::*;

    localparam int MODE_W = 3;

    logic [WIDTH-1:0]        data_q, cfg0_q, cfg1_q, cfg2_q;
    logic [WIDTH-1:0]        sync_q;
    logic [WIDTH-1:0]        ana_vec;
    logic [MODE_W*WIDTH-1:0] mode_flat;
    pin_stat_t               stat_d [WIDTH];
    pin_stat_t               stat_q [WIDTH];

    afio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .data_q  (data_q),
        .cfg0_q  (cfg0_q),
        .cfg1_q  (cfg1_q),
        .cfg2_q  (cfg2_q)
    );

    afio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic [NUM_AF-1:0] af_bits;

        assign mode_flat[MODE_W*i +: MODE_W] = {cfg2_q[i], cfg1_q[i], cfg0_q[i]};

        for (genvar k = 0; k < NUM_AF; k++) begin : g_src
            assign af_bits[k] = af_out[k*WIDTH + i];
        end

        afio_pin_decode #(
            .NUM_AF    (NUM_AF),
            .ANALOG    (ANALOG_MASK[i]),
            .PULLUP_EN (PULLUP_EN)
        ) u_dec (
            .mode     (pin_mode_e'(mode_flat[MODE_W*i +: MODE_W])),
            .data_bit (data_q[i]),
            .af_bits  (af_bits),
            .stat     (stat_d[i])
        );

        // Register pad controls; hold them while the core sleeps
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[i] <= '{out: 1'b1, oe: 1'b0, pu: PULLUP_EN, ana: 1'b0};
            end else if (!sleep) begin
                stat_q[i] <= stat_d[i];
            end
        end

        assign pin_out[i] = stat_q[i].out;
        assign pin_oe[i]  = stat_q[i].oe;
        assign pin_pu[i]  = stat_q[i].pu;
        assign ana_vec[i] = stat_q[i].ana;
        // Pad level seen by peripherals: driven value when driving, else pad input
        assign af_in[i]   = ~stat_q[i].ana & (stat_q[i].oe ? stat_q[i].out : pin_in[i]);
    end

    // Select read data by address
    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = sync_q & ~ana_vec;
            ADDR_CFG0: bus_rdata = cfg0_q;
            ADDR_CFG1: bus_rdata = cfg1_q;
            ADDR_CFG2: bus_rdata = cfg2_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/afio_port_chk.sv
// Module: assertion checker for afio_port, attached with bind below.
// Assumes reset is held for at least two clock edges.
module afio_port_chk #(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] ANALOG_MASK = '0,
    parameter bit               PULLUP_EN   = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep,
    input logic [WIDTH-1:0]   pin_out,
    input logic [WIDTH-1:0]   pin_oe,
    input logic [WIDTH-1:0]   pin_pu,
    input logic [3*WIDTH-1:0] mode_flat
);
    logic live_q     = 1'b0;
    logic rst_seen_q = 1'b0;

    // Track that a clock edge has passed and whether the previous edge was in reset
    always_ff @(posedge clk) begin
        live_q     <= 1'b1;
        rst_seen_q <= !rst_n;
    end

    // R2
    reset_state_chk: assert property (@(posedge clk)
        (live_q && rst_seen_q) |-> (pin_oe == '0 && pin_pu == {WIDTH{PULLUP_EN}} && pin_out == '1));

    // R11
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) |-> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)));

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        // R3
        input_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(sleep) && $past(mode_flat[3*i+1 +: 2]) == 2'b00) |-> !pin_oe[i]);

        // R4
        pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(sleep) && $past(mode_flat[3*i +: 3]) == 3'b010) |-> (pin_oe[i] && !pin_pu[i]));

        // R5
        od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(sleep) && ($past(mode_flat[3*i +: 3]) == 3'b011 ||
                               $past(mode_flat[3*i +: 3]) == 3'b110 ||
                               ($past(mode_flat[3*i +: 3]) == 3'b111 && !ANALOG_MASK[i])))
            |-> (pin_oe[i] == !pin_out[i]));

        // R8
        analog_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ANALOG_MASK[i] && !$past(sleep) && $past(mode_flat[3*i +: 3]) == 3'b111)
            |-> (pin_out[i] && !pin_oe[i] && !pin_pu[i]));
    end

endmodule

bind afio_port afio_port_chk #(
    .WIDTH       (WIDTH),
    .ANALOG_MASK (ANALOG_MASK),
    .PULLUP_EN   (PULLUP_EN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu),
    .mode_flat (mode_flat)
);

// File: tb/afio_port_tb.sv
`timescale 1ns/1ps
module afio_port_tb;
    localparam int         W    = 8;
    localparam int         NAF  = 2;
    localparam logic [7:0] AMSK = 8'hC0;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sleep = 1'b0;
    logic           bus_we = 1'b0;
    logic [1:0]     bus_addr = 2'd0;
    logic [W-1:0]   bus_wdata = '0;
    logic [W-1:0]   bus_rdata;
    logic [W-1:0]   pin_in = '0;
    logic [W-1:0]   pin_out, pin_oe, pin_pu, af_in;
    logic [NAF*W-1:0] af_out = '1;

    int nvec = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    afio_port #(
        .WIDTH(W), .NUM_AF(NAF), .SYNC_STAGES(2), .ANALOG_MASK(AMSK), .PULLUP_EN(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .af_out(af_out), .af_in(af_in)
    );

    task automatic check(input string req, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Write the same mode code to every pin, then wait for the pad registers
    task automatic set_all(input logic [2:0] m);
        wr(2'd1, {W{m[0]}});
        wr(2'd2, {W{m[1]}});
        wr(2'd3, {W{m[2]}});
        @(negedge clk);
    endtask

    task automatic chk_pads(input string req, input logic [W-1:0] o,
                            input logic [W-1:0] e, input logic [W-1:0] p);
        check(req, "pin_out", pin_out, o);
        check(req, "pin_oe", pin_oe, e);
        check(req, "pin_pu", pin_pu, p);
    endtask

    task automatic t_reset();
        logic [W-1:0] r;
        chk_pads("R2", 8'hFF, 8'h00, 8'hFF);
        rd(2'd1, r); check("R2", "cfg0", r, 8'h00);
        rd(2'd2, r); check("R2", "cfg1", r, 8'h00);
        rd(2'd3, r); check("R2", "cfg2", r, 8'hFF);
    endtask

    task automatic t_regs();
        logic [W-1:0] r;
        wr(2'd1, 8'h5A); wr(2'd2, 8'hA5); wr(2'd3, 8'h3C);
        rd(2'd1, r); check("R1", "cfg0 readback", r, 8'h5A);
        rd(2'd2, r); check("R1", "cfg1 readback", r, 8'hA5);
        rd(2'd3, r); check("R1", "cfg2 readback", r, 8'h3C);
    endtask

    task automatic t_input();
        logic [W-1:0] r;
        wr(2'd0, 8'h3C);
        set_all(3'b000);
        chk_pads("R3", 8'h3C, 8'h00, 8'hFF);
        set_all(3'b001);
        chk_pads("R3", 8'h3C, 8'h00, 8'h00);
        bus_addr = 2'd0;
        pin_in = 8'hA5;
        #1; check("R9", "af_in raw", af_in, 8'hA5);
        @(negedge clk); rd(2'd0, r); check("R10", "read after 1 edge", r, 8'h00);
        @(negedge clk); rd(2'd0, r); check("R10", "read after 2 edges", r, 8'hA5);
    endtask

    task automatic t_outputs();
        wr(2'd0, 8'h3C);
        set_all(3'b010); chk_pads("R4", 8'h3C, 8'hFF, 8'h00);
        set_all(3'b011); chk_pads("R5", 8'h3C, 8'hC3, 8'h00);
        set_all(3'b100); chk_pads("R6", 8'h3C, 8'hC3, 8'hFF);
    endtask

    task automatic t_af();
        logic [W-1:0] r;
        af_out = {8'h3C, 8'hF0};
        set_all(3'b101); chk_pads("R7", 8'h30, 8'hFF, 8'h00);
        pin_in = 8'hAA; #1;
        check("R9", "af_in loopback push-pull", af_in, 8'h30);
        set_all(3'b110); chk_pads("R7", 8'h30, 8'hCF, 8'h00);
        check("R9", "af_in open-drain mix", af_in, 8'h20);
        @(negedge clk);
        af_out = {8'hFF, 8'hFF};
        @(negedge clk);
        check("R7", "af change one edge later", pin_out, 8'hFF);
        check("R7", "af release oe", pin_oe, 8'h00);
        set_all(3'b101);
        pin_in = 8'h5A;
        @(negedge clk); @(negedge clk);
        rd(2'd0, r); check("R10", "read in af mode", r, 8'h5A);
    endtask

    task automatic t_analog();
        logic [W-1:0] r;
        af_out = {8'h3C, 8'hF0};
        set_all(3'b111);
        chk_pads("R8", 8'hF0, 8'h0F, 8'h00);
        pin_in = 8'hFF;
        @(negedge clk); @(negedge clk);
        rd(2'd0, r); check("R8", "analog read masked", r, 8'h3F);
        check("R8", "analog af_in masked", af_in, 8'h30);
    endtask

    task automatic t_sleep();
        wr(2'd0, 8'h3C);
        af_out = '1;
        set_all(3'b010);
        chk_pads("R11", 8'h3C, 8'hFF, 8'h00);
        @(negedge clk); sleep = 1'b1;
        wr(2'd0, 8'hC3);
        set_all(3'b011);
        af_out = '0;
        @(negedge clk); @(negedge clk);
        chk_pads("R11", 8'h3C, 8'hFF, 8'h00);
        af_out = '1;
        sleep = 1'b0;
        @(negedge clk);
        chk_pads("R11", 8'hC3, 8'h3C, 8'h00);
    endtask

    // Pin i gets code i; data 0x55; peripheral AND is 1 except on pin 6
    task automatic t_mixed();
        af_out = {8'hBF, 8'hFF};
        wr(2'd0, 8'h55);
        wr(2'd1, 8'hAA); wr(2'd2, 8'hCC); wr(2'd3, 8'hF0);
        @(negedge clk);
        chk_pads("R3 R4 R5 R6 R7 R8 mixed", 8'hB5, 8'h6C, 8'h11);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_input();
        t_outputs();
        t_af();
        t_analog();
        t_sleep();
        t_mixed();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #1600000;
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule